// File: doc/BRIEF.md
# Horizon-Based Circuit Slot Scheduler

This block is the timing core of a central circuit controller for a rack-level optical fabric. A request names a source rack, a destination rack and a circuit length in bytes. Each rack owns a small group of optical-switch channels. The block keeps a table that records, for every channel, the time at which the channel next becomes free. For each side of the request it takes the channel in that rack's group that frees up first. From those two channels it works out a transmission slot, moves both channel horizons to the end of the slot, and queues a grant. The grant carries the slot times and the top-of-rack port that the source must use.

Grants are not returned at once. A grant is held in a short release queue until a free-running scheduler clock reaches the slot start less the control overhead. The source rack therefore gets the grant just in time to switch its data onto the circuit. The line rate is a power-of-two number of bits per cycle, so the slot length in cycles comes from a shift and no divider is needed.

A request moves through a three-state machine. IDLE takes a request when `req_valid` and `req_ready` are both high and moves to SELECT. SELECT reads the horizons of both rack groups, picks the channels and computes the duration, then always moves to COMMIT. COMMIT computes the slot times, writes the horizon table, pushes the grant into the release queue and always returns to IDLE.

Top module: `horizon_slot_scheduler`

## Requirements
- R1: During reset `time_now` is 0, `req_ready` is 1 and `grant_valid` is 0. After reset `time_now` rises by one on every clock edge.
- R2: Rack r owns channels r*CH_PER_RACK to r*CH_PER_RACK+CH_PER_RACK-1. The channel picked for a side is the one in that rack's group with the smallest horizon; on a tie the lowest position wins. All horizons are 0 after reset.
- R3: Let T be the value of `time_now` in the cycle the request is taken. The earliest free time is the largest of three values: the source channel horizon, the destination channel horizon, and T+2.
- R4: The duration is ceil(len*8 / 2^RATE_SHIFT) cycles. The slot start is earliest + T_SWITCH + T_PROC + T_OVH. The slot end is start + duration + T_GUARD. `grant_start` and `grant_end` carry these two values.
- R5: When the request commits, both picked channels take the slot end as their new horizon. A later request that picks either channel sees that value.
- R6: `grant_port` equals PORT_BASE plus the picked source channel's position inside its rack group (channel index mod CH_PER_RACK).
- R7: `grant_valid` is never high before `time_now` reaches start - T_OVH. A grant whose send time has come is shown in that same cycle unless another due grant takes the cycle. Each grant is shown for exactly one cycle.
- R8: When several queued grants are due, the one with the smallest send time is released first, one grant per cycle. The order of requests does not set the order of release.
- R9: `req_ready` is high only in IDLE while fewer than QDEPTH grants are queued. After a request is taken it is low for the next two cycles (SELECT, COMMIT).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_src | input | RACK_W | Source rack identifier (below NUM_RACKS) |
| req_dst | input | RACK_W | Destination rack identifier (below NUM_RACKS) |
| req_len | input | LEN_W | Circuit length in bytes |
| grant_valid | output | 1 | Grant released this cycle |
| grant_port | output | PORT_W | Top-of-rack port for the circuit |
| grant_start | output | TIME_W | Slot start time |
| grant_end | output | TIME_W | Slot end time including guard |
| time_now | output | TIME_W | Free-running scheduler time |

## Verification
The bench steers requests so that later requests arrive at racks whose channels are already busy. If the channel choice ignored horizons, or broke ties upward, the ports and start times would move away from the reference model. One directed sequence queues a long-delayed grant ahead of an early one. A queue that released in arrival order would then emit the later slot first, and a full queue that still raised `req_ready` would be reported as well. Requests with zero length and with the same rack on both sides check the guard-only slot and the case where both table writes go to one channel. The bench also flags any cycle in which a due grant is held back, and any grant that appears before its send time.

// File: rtl/horizon_sched_pkg.sv
package horizon_sched_pkg;
    parameter int TIME_W = 32;
    parameter int PORT_W = 8;

    typedef logic [TIME_W-1:0] stamp_t;

    typedef struct packed {
        stamp_t              send;
        stamp_t              start;
        stamp_t              fin;
        logic [PORT_W-1:0]   port;
    } grant_t;

    function automatic stamp_t later(input stamp_t a, input stamp_t b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/hsched_chan_pick.sv
module hsched_chan_pick
    import horizon_sched_pkg::*;
#(
    parameter int CPR = 2,
    localparam int KW = (CPR > 1) ? $clog2(CPR) : 1
) (
    input  stamp_t [CPR-1:0] hz,
    output logic   [KW-1:0]  pick_idx
);
    stamp_t best;

    // earliest-free channel, lowest position wins ties
    always_comb begin
        pick_idx = '0;
        best     = hz[0];
        for (int k = 1; k < CPR; k++) begin
            if (hz[k] < best) begin
                best     = hz[k];
                pick_idx = KW'(k);
            end
        end
    end
endmodule

// File: rtl/hsched_release_q.sv
module hsched_release_q
    import horizon_sched_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  stamp_t now,
    input  logic   push,
    input  grant_t push_d,
    output logic   full,
    output logic   out_valid,
    output grant_t out_d
);
    grant_t           ent_q [DEPTH];
    logic [DEPTH-1:0] vld_q;
    logic [IW-1:0]    free_idx;
    logic [IW-1:0]    pick_idx;

    assign full  = &vld_q;
    assign out_d = ent_q[pick_idx];

    always_comb begin
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!vld_q[i]) free_idx = IW'(i);
        end
    end

    // among due entries take the smallest send time
    always_comb begin
        out_valid = 1'b0;
        pick_idx  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (vld_q[i] && ent_q[i].send <= now &&
                (!out_valid || ent_q[i].send < ent_q[pick_idx].send)) begin
                out_valid = 1'b1;
                pick_idx  = IW'(i);
            end
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[g] <= 1'b0;
                ent_q[g] <= '0;
            end else if (push && free_idx == IW'(g)) begin
                vld_q[g] <= 1'b1;
                ent_q[g] <= push_d;
            end else if (out_valid && pick_idx == IW'(g)) begin
                vld_q[g] <= 1'b0;
            end
        end
    end

    assert_no_push_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    assert_count_track_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(vld_q) ==
                  $countones($past(vld_q)) + int'($past(push)) - int'($past(out_valid))));
endmodule

// File: rtl/horizon_slot_scheduler.sv
module horizon_slot_scheduler
    import horizon_sched_pkg::*;
#(
    parameter int NUM_RACKS   = 20,
    parameter int CH_PER_RACK = 2,
    parameter int LEN_W       = 16,
    parameter int RATE_SHIFT  = 3,
    parameter int T_SWITCH    = 4,
    parameter int T_PROC      = 200,
    parameter int T_OVH       = 6,
    parameter int T_GUARD     = 3,
    parameter int PORT_BASE   = 8,
    parameter int QDEPTH      = 4,
    localparam int RACK_W     = (NUM_RACKS > 1) ? $clog2(NUM_RACKS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [RACK_W-1:0]  req_src,
    input  logic [RACK_W-1:0]  req_dst,
    input  logic [LEN_W-1:0]   req_len,
    output logic               grant_valid,
    output logic [PORT_W-1:0]  grant_port,
    output logic [TIME_W-1:0]  grant_start,
    output logic [TIME_W-1:0]  grant_end,
    output logic [TIME_W-1:0]  time_now
);
    localparam int NUM_CH = NUM_RACKS * CH_PER_RACK;
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int KW     = (CH_PER_RACK > 1) ? $clog2(CH_PER_RACK) : 1;
    localparam int BITS_W = LEN_W + 4;

    typedef enum logic [1:0] {S_IDLE, S_SELECT, S_COMMIT} state_t;

    state_t state_q, state_d;
    stamp_t now_q;
    stamp_t hz_q [NUM_CH];

    logic [RACK_W-1:0] src_q, dst_q;
    logic [LEN_W-1:0]  len_q;
    logic [CH_W-1:0]   src_ch_q, dst_ch_q;
    logic [KW-1:0]     ks_q;
    stamp_t            hs_q, hd_q, dur_q;

    stamp_t [CH_PER_RACK-1:0] src_slice, dst_slice;
    logic [KW-1:0]            ks, kd;
    logic [BITS_W-1:0]        bits_rnd;
    stamp_t                   earliest_c, send_c, start_c, fin_c;
    grant_t                   push_d, out_d;
    logic                     q_full, q_out;
    logic                     accept, commit;

    assign accept = req_valid && req_ready;
    assign commit = (state_q == S_COMMIT);

    // ---------------- state register and transitions
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (accept) state_d = S_SELECT;
            S_SELECT: state_d = S_COMMIT;
            S_COMMIT: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // ---------------- outputs
    always_comb begin
        req_ready   = (state_q == S_IDLE) && !q_full;
        grant_valid = q_out;
        grant_port  = out_d.port;
        grant_start = out_d.start;
        grant_end   = out_d.fin;
        time_now    = now_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) now_q <= '0;
        else        now_q <= now_q + 1'b1;
    end

    // ---------------- channel selection (SELECT)
    always_comb begin
        for (int k = 0; k < CH_PER_RACK; k++) begin
            src_slice[k] = hz_q[CH_W'(int'(src_q) * CH_PER_RACK + k)];
            dst_slice[k] = hz_q[CH_W'(int'(dst_q) * CH_PER_RACK + k)];
        end
    end

    hsched_chan_pick #(.CPR(CH_PER_RACK)) u_pick_src (.hz(src_slice), .pick_idx(ks));
    hsched_chan_pick #(.CPR(CH_PER_RACK)) u_pick_dst (.hz(dst_slice), .pick_idx(kd));

    // ceil(len*8 / 2^RATE_SHIFT)
    assign bits_rnd = {1'b0, len_q, 3'b000} + BITS_W'((1 << RATE_SHIFT) - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0; dst_q <= '0; len_q <= '0;
            src_ch_q <= '0; dst_ch_q <= '0; ks_q <= '0;
            hs_q <= '0; hd_q <= '0; dur_q <= '0;
        end else if (accept) begin
            src_q <= req_src;
            dst_q <= req_dst;
            len_q <= req_len;
        end else if (state_q == S_SELECT) begin
            src_ch_q <= CH_W'(int'(src_q) * CH_PER_RACK + int'(ks));
            dst_ch_q <= CH_W'(int'(dst_q) * CH_PER_RACK + int'(kd));
            ks_q     <= ks;
            hs_q     <= src_slice[ks];
            hd_q     <= dst_slice[kd];
            dur_q    <= TIME_W'(bits_rnd >> RATE_SHIFT);
        end
    end

    // ---------------- slot arithmetic (COMMIT)
    always_comb begin
        earliest_c = later(later(hs_q, hd_q), now_q);
        send_c     = earliest_c + TIME_W'(T_SWITCH) + TIME_W'(T_PROC);
        start_c    = send_c + TIME_W'(T_OVH);
        fin_c      = start_c + dur_q + TIME_W'(T_GUARD);
        push_d     = '{send: send_c, start: start_c, fin: fin_c,
                       port: PORT_W'(PORT_BASE) + PORT_W'(ks_q)};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CH; c++) hz_q[c] <= '0;
        end else if (commit) begin
            hz_q[src_ch_q] <= fin_c;
            hz_q[dst_ch_q] <= fin_c;
        end
    end

    hsched_release_q #(.DEPTH(QDEPTH)) u_relq (
        .clk(clk), .rst_n(rst_n), .now(now_q),
        .push(commit), .push_d(push_d),
        .full(q_full), .out_valid(q_out), .out_d(out_d)
    );

    // ---------------- assertions
    assert_clock_advance_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (time_now == $past(time_now) + 1'b1));

    assert_ready_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

    assert_horizon_written_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (hz_q[src_ch_q] == $past(fin_c) && hz_q[dst_ch_q] == $past(fin_c)));

    assert_grant_not_early_R7: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (grant_start - TIME_W'(T_OVH) <= time_now));
endmodule

// File: tb/horizon_slot_scheduler_bench.sv
module horizon_slot_scheduler_bench;
    localparam int NR = 20, CPR = 2, RS = 3;
    localparam int TSW = 4, TPR = 200, TOV = 6, TGD = 3, PB = 8, QD = 4;
    localparam int SLOTS = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [4:0]  req_src = '0, req_dst = '0;
    logic [15:0] req_len = '0;
    logic        grant_valid;
    logic [7:0]  grant_port;
    logic [31:0] grant_start, grant_end, time_now;

    always #2.5 clk = ~clk;

    horizon_slot_scheduler u_horizon_slot_scheduler (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_src(req_src), .req_dst(req_dst), .req_len(req_len),
        .grant_valid(grant_valid), .grant_port(grant_port),
        .grant_start(grant_start), .grant_end(grant_end), .time_now(time_now)
    );

    int nchk = 0, nfail = 0, busy = 0;
    longint bhz [NR*CPR];
    longint e_send [SLOTS], e_start [SLOTS], e_end [SLOTS], e_port [SLOTS];
    bit     e_live [SLOTS];

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0d", tag, act, exp, time_now);
        end
    endtask

    function automatic int live_cnt();
        int n = 0;
        for (int i = 0; i < SLOTS; i++) if (e_live[i]) n++;
        return n;
    endfunction

    function automatic int pick(input int rack);
        int k = 0;
        for (int j = 1; j < CPR; j++) if (bhz[rack*CPR+j] < bhz[rack*CPR+k]) k = j;
        return k;
    endfunction

    // reference model of R2..R6 for one accepted request
    task automatic model_accept(input int s, input int d, input int l, input longint a);
        int ks, kd, sc, dc, slot;
        longint e, st, fn, dur;
        ks = pick(s); kd = pick(d);
        sc = s*CPR + ks; dc = d*CPR + kd;
        e = bhz[sc];
        if (bhz[dc] > e) e = bhz[dc];
        if (a + 2 > e) e = a + 2;
        dur = (longint'(l)*8 + (1 << RS) - 1) >> RS;
        st = e + TSW + TPR + TOV;
        fn = st + dur + TGD;
        bhz[sc] = fn; bhz[dc] = fn;
        slot = -1;
        for (int i = 0; i < SLOTS; i++) if (!e_live[i] && slot < 0) slot = i;
        e_live[slot] = 1; e_send[slot] = st - TOV; e_start[slot] = st;
        e_end[slot] = fn; e_port[slot] = PB + ks;
    endtask

    task automatic tick(input bit go, input int s, input int d, input int l, output bit took);
        @(negedge clk);
        check(req_ready == ((busy == 0) && (live_cnt() < QD)), "R9 req_ready",
              req_ready, (busy == 0) && (live_cnt() < QD));
        if (grant_valid) begin
            longint ms = -1;
            int j = -1;
            for (int i = 0; i < SLOTS; i++)
                if (e_live[i] && (ms < 0 || e_send[i] < ms)) ms = e_send[i];
            for (int i = 0; i < SLOTS; i++)
                if (e_live[i] && e_send[i] == ms && (j < 0 || e_start[i] == grant_start)) j = i;
            if (j < 0) check(0, "R7 grant with nothing pending", 1, 0);
            else begin
                check(time_now >= e_send[j], "R7 grant before send time", time_now, e_send[j]);
                check(grant_start == e_start[j], "R3 R4 slot start (R8 order)", grant_start, e_start[j]);
                check(grant_end == e_end[j], "R4 R5 slot end", grant_end, e_end[j]);
                check(grant_port == e_port[j], "R2 R6 port", grant_port, e_port[j]);
                e_live[j] = 0;
            end
        end else begin
            for (int i = 0; i < SLOTS; i++)
                if (e_live[i] && e_send[i] <= time_now)
                    check(0, "R7 due grant held back", time_now, e_send[i]);
        end
        if (busy > 0) busy--;
        took = 0;
        req_valid = 1'b0;
        if (go && req_ready) begin
            req_valid = 1'b1;
            req_src = 5'(s); req_dst = 5'(d); req_len = 16'(l);
            model_accept(s, d, l, longint'(time_now));
            busy = 2;
            took = 1;
        end
    endtask

    task automatic issue(input int s, input int d, input int l);
        bit took = 0;
        while (!took) tick(1, s, d, l, took);
    endtask

    task automatic idle(input int n);
        bit took;
        for (int i = 0; i < n; i++) tick(0, 0, 0, 0, took);
    endtask

    task automatic drain();
        int guard = 0;
        while (live_cnt() > 0 && guard < 20000) begin idle(1); guard++; end
        check(live_cnt() == 0, "R7 drain", live_cnt(), 0);
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL R7 watchdog expired");
        finish_run();
    end

    initial begin
        bit took;
        int r;
        for (int i = 0; i < NR*CPR; i++) bhz[i] = 0;
        for (int i = 0; i < SLOTS; i++) e_live[i] = 0;
        r = $urandom(32'd4242);

        // R1: reset state
        repeat (3) @(negedge clk);
        check(time_now == 0, "R1 reset time", time_now, 0);
        check(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
        check(grant_valid == 1'b0, "R1 reset grant", grant_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(time_now == 1, "R1 first count", time_now, 1);
        @(negedge clk);
        check(time_now == 2, "R1 second count", time_now, 2);

        // R2 R8 R9: busy channels, out-of-order release, full queue
        issue(0, 1, 300);
        issue(0, 1, 300);
        issue(0, 1, 10);
        issue(2, 3, 10);
        idle(3);
        check(req_ready == 1'b0, "R9 full queue blocks", req_ready, 0);
        drain();

        // R4 R5: zero length, same rack on both sides, then reuse
        issue(5, 5, 0);
        issue(6, 5, 20);
        issue(5, 6, 7);
        drain();

        // constrained random
        for (int c = 0; c < 20000; c++) begin
            bit go = ($urandom % 2) == 0;
            tick(go, int'($urandom % NR), int'($urandom % NR), int'($urandom % 64), took);
        end
        drain();
        finish_run();
    end
endmodule